// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block works out the next program counter value for an 8-bit processor whose program memory is addressed in words. Each cycle in which the advance strobe is high, it takes the current PC and the decoded flow-control kind and computes the next PC. That PC can be a straight step past a one-word or two-word instruction, a PC-relative jump or call, an absolute jump or call, a jump or call through the 16-bit Z pointer, or a jump or call through an 8-bit extension byte placed above Z.

In the same cycle it computes the address of the instruction that follows the current one. For the four call kinds it raises a push request so that the surrounding core can save that address on its stack. The results are registered: they appear one clock after the advance strobe and are held while the strobe is low.

The block has no multi-state sequencing. Its only state is the registered result stage, which sits in one of two named conditions: *holding* when the advance strobe is low, and *loading* when it is high. A transition from holding to loading happens on any cycle with the strobe set. The width of the PC is the parameter `PC_W`, which may be 16 to 22.

Top module: `pcnu_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `next_pc_o`, `ret_addr_o` and `push_o` are all zero.
- R2: Results appear on the outputs one clock after `adv_i` is sampled high. While `adv_i` is low, `next_pc_o` and `ret_addr_o` keep their values and `push_o` is 0 one clock later.
- R3: Kind code 0 (one-word step) gives PC+1. Kind code 1 (two-word step) gives PC+2. Both wrap modulo 2^PC_W.
- R4: Kind codes 2 (relative jump) and 3 (relative call) give PC + k + 1. Here k is `rel_off_i` read as a 12-bit two's-complement value from -2048 to 2047, and the sum wraps modulo 2^PC_W.
- R5: Kind codes 4 (absolute jump) and 5 (absolute call) give the low PC_W bits of `abs_tgt_i`. Its upper bits have no effect.
- R6: Kind codes 6 (Z jump) and 7 (Z call) give `z_i` zero-extended to PC_W bits.
- R7: Kind codes 8 (extended jump) and 9 (extended call) give the low PC_W bits of {`ext_i`, `z_i`}. With PC_W = 16, `ext_i` has no effect.
- R8: `ret_addr_o` is the address of the following instruction. It is PC+2 for the two-word kinds (codes 1, 4, 5) and PC+1 for every other kind, wrapping modulo 2^PC_W.
- R9: `push_o` is 1 exactly after an advance with a call kind (codes 3, 5, 7, 9). It is 0 after every jump or step kind.
- R10: Unused kind codes 10 to 15 behave as code 0: the next PC is PC+1, the return address is PC+1, and there is no push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Advance strobe: compute and register a new result |
| kind_i | input | 4 | Flow-control kind code |
| pc_i | input | PC_W | Current program counter |
| rel_off_i | input | 12 | Signed relative offset k |
| abs_tgt_i | input | 22 | Absolute target from the instruction |
| z_i | input | 16 | Z pointer value |
| ext_i | input | 8 | Extension byte placed above Z |
| next_pc_o | output | PC_W | Registered next PC |
| ret_addr_o | output | PC_W | Registered address of the following instruction |
| push_o | output | 1 | Registered push request for calls |

## Verification
On every cycle, the embedded properties check four things against the inputs of the previous cycle: that held outputs stay stable, that push follows only call kinds, that one-word steps and absolute targets land where expected, and that the return address matches the instruction length. The bench is needed for the full arithmetic. It sweeps every one of the 4096 relative offsets from PCs near zero and near the wrap point, and runs every kind code against several operand patterns on a 22-bit and a 16-bit instance. Only the bench can show that extension and upper target bits are dropped at the narrower width and that unused codes fall back to a plain step.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;

    typedef enum logic [3:0] {
        KIND_STEP1  = 4'd0,
        KIND_STEP2  = 4'd1,
        KIND_RJMP   = 4'd2,
        KIND_RCALL  = 4'd3,
        KIND_AJMP   = 4'd4,
        KIND_ACALL  = 4'd5,
        KIND_ZJMP   = 4'd6,
        KIND_ZCALL  = 4'd7,
        KIND_XZJMP  = 4'd8,
        KIND_XZCALL = 4'd9
    } flow_kind_e;

    localparam int OFF_W = 12;
    localparam int ABS_W = 22;
    localparam int Z_W   = 16;
    localparam int EXT_W = 8;

    function automatic logic kind_is_call(input logic [3:0] k);
        return (k == KIND_RCALL) || (k == KIND_ACALL) ||
               (k == KIND_ZCALL) || (k == KIND_XZCALL);
    endfunction

    function automatic logic kind_is_two_word(input logic [3:0] k);
        return (k == KIND_STEP2) || (k == KIND_AJMP) || (k == KIND_ACALL);
    endfunction

endpackage

// File: rtl/pcnu_rel_add.sv
module pcnu_rel_add #(
    parameter int PC_W  = 22,
    parameter int OFF_W = 12
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PC_W-1:0]  sum_o
);
    localparam int EXT_BITS = PC_W - OFF_W;

    logic [PC_W-1:0] off_sx;

    always_comb begin
        off_sx = {{EXT_BITS{off_i[OFF_W-1]}}, off_i};
        sum_o  = pc_i + off_sx + PC_W'(1);
    end

    initial begin
        assert (PC_W > OFF_W) else $error("PC_W must exceed offset width");
    end
endmodule

// File: rtl/pcnu_tgt_sel.sv
module pcnu_tgt_sel
    import pcnu_pkg::*;
#(
    parameter int PC_W = 22
) (
    input  logic [3:0]       kind_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [PC_W-1:0]  rel_sum_i,
    input  logic [ABS_W-1:0] abs_i,
    input  logic [Z_W-1:0]   z_i,
    input  logic [EXT_W-1:0] ext_i,
    output logic [PC_W-1:0]  next_o,
    output logic [PC_W-1:0]  ret_o,
    output logic             push_o
);
    localparam int WIDE_W = Z_W + EXT_W;

    logic [WIDE_W-1:0] z_wide;
    logic [WIDE_W-1:0] xz_wide;
    logic [PC_W-1:0]   pc_p1;
    logic [PC_W-1:0]   pc_p2;

    always_comb begin
        z_wide  = {{EXT_W{1'b0}}, z_i};
        xz_wide = {ext_i, z_i};
        pc_p1   = pc_i + PC_W'(1);
        pc_p2   = pc_i + PC_W'(2);
    end

    always_comb begin
        unique case (kind_i)
            KIND_STEP1:              next_o = pc_p1;
            KIND_STEP2:              next_o = pc_p2;
            KIND_RJMP, KIND_RCALL:   next_o = rel_sum_i;
            KIND_AJMP, KIND_ACALL:   next_o = abs_i[PC_W-1:0];
            KIND_ZJMP, KIND_ZCALL:   next_o = z_wide[PC_W-1:0];
            KIND_XZJMP, KIND_XZCALL: next_o = xz_wide[PC_W-1:0];
            default:                 next_o = pc_p1;
        endcase
        ret_o  = kind_is_two_word(kind_i) ? pc_p2 : pc_p1;
        push_o = kind_is_call(kind_i);
    end

    always_comb begin
        AST_STEP_SEL: assert (!(kind_i == KIND_STEP1) || next_o == pc_p1)
            else $error("one-word step mismatch"); // R3
    end
endmodule

// File: rtl/pcnu_top.sv
module pcnu_top
    import pcnu_pkg::*;
#(
    parameter int PC_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [3:0]       kind_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [11:0]      rel_off_i,
    input  logic [21:0]      abs_tgt_i,
    input  logic [15:0]      z_i,
    input  logic [7:0]       ext_i,
    output logic [PC_W-1:0]  next_pc_o,
    output logic [PC_W-1:0]  ret_addr_o,
    output logic             push_o
);
    logic [PC_W-1:0] rel_sum;
    logic [PC_W-1:0] nxt_c;
    logic [PC_W-1:0] ret_c;
    logic            push_c;

    pcnu_rel_add #(.PC_W(PC_W), .OFF_W(OFF_W)) u_rel (
        .pc_i  (pc_i),
        .off_i (rel_off_i),
        .sum_o (rel_sum)
    );

    pcnu_tgt_sel #(.PC_W(PC_W)) u_sel (
        .kind_i    (kind_i),
        .pc_i      (pc_i),
        .rel_sum_i (rel_sum),
        .abs_i     (abs_tgt_i),
        .z_i       (z_i),
        .ext_i     (ext_i),
        .next_o    (nxt_c),
        .ret_o     (ret_c),
        .push_o    (push_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_o  <= '0;
            ret_addr_o <= '0;
            push_o     <= 1'b0;
        end else if (adv_i) begin
            next_pc_o  <= nxt_c;
            ret_addr_o <= ret_c;
            push_o     <= push_c;
        end else begin
            push_o     <= 1'b0;
        end
    end

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> ($stable(next_pc_o) && $stable(ret_addr_o) && !push_o)); // R2

    AST_PUSH_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> ($past(adv_i) && kind_is_call($past(kind_i)))); // R9

    AST_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && kind_i == KIND_STEP1) |=> next_pc_o == $past(pc_i) + PC_W'(1)); // R3

    AST_ABS_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && kind_i == KIND_AJMP) |=> next_pc_o == $past(abs_tgt_i[PC_W-1:0])); // R5

    AST_RET_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && kind_i == KIND_ACALL) |=> ret_addr_o == $past(pc_i) + PC_W'(2)); // R8
endmodule

// File: tb/tb_pcnu_top.sv
module tb_pcnu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv = 1'b0;
    logic [3:0]  kind = '0;
    logic [21:0] pc = '0;
    logic [11:0] off = '0;
    logic [21:0] abs_t = '0;
    logic [15:0] z = '0;
    logic [7:0]  ext = '0;

    logic [21:0] nxt_w, ret_w;
    logic        push_w;
    logic [15:0] nxt_n, ret_n;
    logic        push_n;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pcnu_top #(.PC_W(22)) dut (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .kind_i(kind), .pc_i(pc),
        .rel_off_i(off), .abs_tgt_i(abs_t), .z_i(z), .ext_i(ext),
        .next_pc_o(nxt_w), .ret_addr_o(ret_w), .push_o(push_w)
    );

    pcnu_top #(.PC_W(16)) dut_n (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .kind_i(kind), .pc_i(pc[15:0]),
        .rel_off_i(off), .abs_tgt_i(abs_t), .z_i(z), .ext_i(ext),
        .next_pc_o(nxt_n), .ret_addr_o(ret_n), .push_o(push_n)
    );

    task automatic chk(input string req, input longint got, input longint exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic longint msk(input int w);
        return (longint'(1) << w) - 1;
    endfunction

    function automatic longint exp_next(input int w, input int k, input longint p,
                                        input longint o, input longint a,
                                        input longint zz, input longint e);
        longint so;
        so = (o >= 2048) ? o - 4096 : o;
        case (k)
            1:       return (p + 2) & msk(w);
            2, 3:    return (p + so + 1) & msk(w);
            4, 5:    return a & msk(w);
            6, 7:    return zz & msk(w);
            8, 9:    return ((e << 16) | zz) & msk(w);
            default: return (p + 1) & msk(w);
        endcase
    endfunction

    function automatic string req_of(input int k);
        case (k)
            0, 1:    return "R3";
            2, 3:    return "R4";
            4, 5:    return "R5";
            6, 7:    return "R6";
            8, 9:    return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic step(input int k, input logic [21:0] p, input logic [11:0] o,
                        input logic [21:0] a, input logic [15:0] zz, input logic [7:0] e);
        longint r_w, r_n;
        bit call, two;
        @(negedge clk);
        adv = 1'b1; kind = 4'(k); pc = p; off = o; abs_t = a; z = zz; ext = e;
        @(posedge clk);
        #1;
        call = (k == 3) || (k == 5) || (k == 7) || (k == 9);
        two  = (k == 1) || (k == 4) || (k == 5);
        r_w = (longint'(p) + (two ? 2 : 1)) & msk(22);
        r_n = (longint'(p) + (two ? 2 : 1)) & msk(16);
        chk(req_of(k), nxt_w, exp_next(22, k, p, o, a, zz, e));
        chk(req_of(k), nxt_n, exp_next(16, k, p, o, a, zz, e));
        chk("R8", ret_w, r_w);
        chk("R8", ret_n, r_n);
        chk("R9", push_w, call);
        chk("R9", push_n, call);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [21:0] pcs [4];
        logic [21:0] held_w;
        pcs[0] = 22'h000000; pcs[1] = 22'h000005;
        pcs[2] = 22'h3FFFFE; pcs[3] = 22'h00FFFF;

        repeat (3) @(posedge clk);
        #1;
        chk("R1", nxt_w, 0); chk("R1", ret_w, 0); chk("R1", push_w, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", nxt_n, 0); chk("R1", push_n, 0);

        // R4: every relative offset from several PCs, incl. wrap points
        for (int i = 0; i < 4; i++)
            for (int o = 0; o < 4096; o++)
                step(2 + (o & 1), pcs[i], 12'(o), 22'h0, 16'h0, 8'h0);

        // R3 R5 R6 R7 R8 R9 R10: every kind code against operand patterns
        for (int i = 0; i < 4; i++)
            for (int k = 0; k < 16; k++) begin
                step(k, pcs[i], 12'h800, 22'h3ABCDE, 16'hFFFF, 8'hC3);
                step(k, pcs[i] ^ 22'h15555, 12'h7FF, 22'h012345, 16'h8001, 8'h3F);
            end

        // R2: hold while advance is low
        step(5, 22'h001234, 12'h0, 22'h2AAAAA, 16'h0, 8'h0);
        held_w = nxt_w;
        @(negedge clk);
        adv = 1'b0; kind = 4'd0; pc = 22'h000777; abs_t = 22'h0;
        @(posedge clk); #1;
        chk("R2", nxt_w, held_w);
        chk("R2", ret_w, 22'h001236);
        chk("R2", push_w, 0);
        @(posedge clk); #1;
        chk("R2", nxt_w, held_w);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule